// File: doc/BRIEF.md
# Asynchronous Static Memory Bridge

This bridge turns single read and write requests from an on-chip bus into timed cycles on an asynchronous 16-bit static memory, such as an SRAM, a ROM or a NOR flash. The bus side uses a valid/ready handshake. The memory side has a halfword address, active-low chip select, output enable, write enable and two byte-lane enables, plus a 16-bit data path that is split into output, drive-enable and input. No memory clock is produced. Every memory-side output is a flop that changes only on the rising edge of the system clock.

Each memory cycle has three parts: an address setup phase, a data phase and an optional bus-turnaround gap. Reads and writes each have their own three counts, which arrive as static inputs. A 32-bit transfer becomes two consecutive halfword cycles. An 8-bit write is narrowed to one byte lane. Narrow reads fetch the whole halfword and return only the requested part. Read data is captured on the last clock of the data phase, while chip select is still low.

Top module: `sram_bridge`

## Requirements
- R1: While reset is high, and on the first cycle after it, chip select, output enable, write enable and both byte lanes are high, the data driver is off, and `req_ready` is low.
- R2: A write holds chip select low and the byte lanes at their value for `wr_setup` cycles with write enable high. It then holds write enable low for exactly `wr_data` cycles, and then keeps chip select low one more cycle with write enable high. Address and write data are driven and stable for the whole time chip select is low.
- R3: A read holds chip select low for `rd_setup` cycles with output enable high. It then holds output enable low for `rd_data` cycles. Both strobes rise together after that. The data driver stays off, the byte lanes are both low (value 2'b00), and the value on `mem_dq_in` is captured at the clock edge that ends the data phase.
- R4: The timing set used for a cycle depends only on its direction. Read counts never change a write cycle, and write counts never change a read cycle.
- R5: `req_size` encodes 0 = byte, 1 = halfword, 2 = word. A byte write drives the byte on both halves of the data bus. It sets `mem_be_n` to 2'b10 when address bit 0 is 0 (low lane) and to 2'b01 when it is 1 (high lane). Halfword and word writes use 2'b00.
- R6: A byte read returns the addressed byte of the halfword in `rsp_rdata[7:0]`: bits 7:0 when address bit 0 is 0, bits 15:8 otherwise. A halfword read returns the halfword in bits 15:0. The unused upper bits are zero.
- R7: A word transfer makes two memory cycles. The first uses halfword address `req_addr[ADDR_W-1:1]` with data bits 15:0. The second uses that address plus one with data bits 31:16. The two are separated by exactly the turnaround count of chip-select-high cycles, and a read returns {second, first}.
- R8: After every memory cycle, chip select stays high for the turnaround count. A new request is first taken max(turn,1) cycles after the cycle in which `req_ready` was high, even if `req_valid` never dropped.
- R9: `req_ready` is high for exactly one cycle per request. That cycle directly follows the final memory cycle and has chip select high. For a read, `rsp_rdata` holds the result in that cycle.
- R10: A setup or data count of zero behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address (halfword/word aligned for wider sizes) |
| req_wdata | input | 32 | Write data, byte in bits 7:0, halfword in 15:0 |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with `req_ready` |
| rd_setup | input | SETUP_W | Read address-setup cycles |
| rd_data | input | DATA_W | Read data-phase cycles |
| rd_turn | input | TURN_W | Read turnaround cycles |
| wr_setup | input | SETUP_W | Write address-setup cycles |
| wr_data | input | DATA_W | Write-enable low cycles |
| wr_turn | input | TURN_W | Write turnaround cycles |
| mem_addr | output | ADDR_W-1 | Halfword address to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 2 | Byte-lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Write data to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Read data from memory |

## Verification
The bench drives a small memory that reacts to the strobes. It compares every memory-side output on every clock against a waveform built in the bench from the timing counts. Word transfers are run with and without a turnaround gap between their halves: a bridge that ended after one half, or used the wrong address order, would leave the upper halfword stale or swap it. Byte writes to both lanes are followed by halfword reads, so an inverted lane encoding shows up as a corrupted neighbour byte. Requests are also kept valid straight through the ready cycle, so a bridge that took a new request during turnaround would start its setup cycle too early. A second timing set with zero counts checks that each direction uses its own counts and that zero is treated as one.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_DATA,
    PH_WREL,
    PH_GAP
  } phase_e;

endpackage

// File: rtl/sbb_tsel.sv
module sbb_tsel #(
  parameter int SETUP_W = 4,
  parameter int DATA_W  = 8,
  parameter int TURN_W  = 4
) (
  input  logic               is_wr,
  input  logic [SETUP_W-1:0] rd_setup,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [TURN_W-1:0]  rd_turn,
  input  logic [SETUP_W-1:0] wr_setup,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [TURN_W-1:0]  wr_turn,
  output logic [SETUP_W-1:0] eff_setup,
  output logic [DATA_W-1:0]  eff_data,
  output logic [TURN_W-1:0]  eff_turn
);

  logic [SETUP_W-1:0] raw_setup;
  logic [DATA_W-1:0]  raw_data;

  always_comb begin
    raw_setup = is_wr ? wr_setup : rd_setup;
    raw_data  = is_wr ? wr_data  : rd_data;
    eff_turn  = is_wr ? wr_turn  : rd_turn;
    // zero counts are promoted to one so every phase lasts at least a clock
    eff_setup = (raw_setup == '0) ? SETUP_W'(1) : raw_setup;
    eff_data  = (raw_data == '0)  ? DATA_W'(1)  : raw_data;
  end

endmodule

// File: rtl/sbb_lane.sv
module sbb_lane
  import sbb_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  xfer_size_e        size,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              hi,
  input  logic [15:0]       rd_lo,
  input  logic [15:0]       rd_now,
  output logic [ADDR_W-2:0] hw_addr,
  output logic [1:0]        be_n,
  output logic [15:0]       wdq,
  output logic [31:0]       rdata
);

  localparam int HW = ADDR_W - 1;

  logic narrow_wr;
  assign narrow_wr = is_wr && (size == SZ_BYTE);
  assign hw_addr   = addr[ADDR_W-1:1] + HW'(hi);

  // lane g is disabled only for a byte write aimed at the other lane
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign be_n[g] = narrow_wr && (addr[0] != 1'(g));
  end

  always_comb begin
    case (size)
      SZ_BYTE: wdq = {wdata[7:0], wdata[7:0]};
      SZ_WORD: wdq = hi ? wdata[31:16] : wdata[15:0];
      default: wdq = wdata[15:0];
    endcase
    case (size)
      SZ_BYTE: rdata = {24'd0, addr[0] ? rd_now[15:8] : rd_now[7:0]};
      SZ_WORD: rdata = {rd_now, rd_lo};
      default: rdata = {16'd0, rd_now};
    endcase
  end

endmodule

// File: rtl/sbb_seq.sv
module sbb_seq
  import sbb_pkg::*;
#(
  parameter int SETUP_W = 4,
  parameter int DATA_W  = 8,
  parameter int TURN_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               is_wr,
  input  logic               split,
  input  logic [SETUP_W-1:0] setup_c,
  input  logic [DATA_W-1:0]  data_c,
  input  logic [TURN_W-1:0]  turn_c,
  output logic               in_idle,
  output logic               accept,
  output phase_e             ph_n,
  output logic               hi_n,
  output logic               cap,
  output logic               fin,
  output logic               ready
);

  localparam int CW_A = (SETUP_W > TURN_W) ? SETUP_W : TURN_W;
  localparam int CW   = (DATA_W > CW_A) ? DATA_W : CW_A;

  phase_e        ph;
  logic [CW-1:0] cnt, cnt_n;
  logic          hi;
  logic          cnt_z, last, acc_end;

  assign in_idle = (ph == PH_IDLE);

  always_comb begin
    ph_n    = ph;
    cnt_n   = cnt;
    hi_n    = hi;
    cap     = 1'b0;
    fin     = 1'b0;
    acc_end = 1'b0;
    cnt_z   = (cnt == '0);
    last    = !split || hi;
    accept  = (ph == PH_IDLE) && req_valid && !ready;
    case (ph)
      PH_IDLE: if (accept) begin
        ph_n  = PH_SETUP;
        cnt_n = CW'(setup_c) - CW'(1);
        hi_n  = 1'b0;
      end
      PH_SETUP: if (cnt_z) begin
        ph_n  = PH_DATA;
        cnt_n = CW'(data_c) - CW'(1);
      end else begin
        cnt_n = cnt - CW'(1);
      end
      PH_DATA: if (!cnt_z) begin
        cnt_n = cnt - CW'(1);
      end else if (is_wr) begin
        ph_n = PH_WREL;
      end else begin
        cap     = 1'b1;
        acc_end = 1'b1;
      end
      PH_WREL: acc_end = 1'b1;
      PH_GAP: if (!cnt_z) begin
        cnt_n = cnt - CW'(1);
      end else if (!last) begin
        ph_n  = PH_SETUP;
        hi_n  = 1'b1;
        cnt_n = CW'(setup_c) - CW'(1);
      end else begin
        ph_n = PH_IDLE;
      end
      default: ph_n = PH_IDLE;
    endcase
    if (acc_end) begin
      fin = last;
      if (turn_c != '0) begin
        ph_n  = PH_GAP;
        cnt_n = CW'(turn_c) - CW'(1);
      end else if (!last) begin
        ph_n  = PH_SETUP;
        hi_n  = 1'b1;
        cnt_n = CW'(setup_c) - CW'(1);
      end else begin
        ph_n = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      hi    <= 1'b0;
      ready <= 1'b0;
    end else begin
      ph    <= ph_n;
      cnt   <= cnt_n;
      hi    <= hi_n;
      ready <= fin;
    end
  end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sbb_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SETUP_W = 4,
  parameter int DATA_W  = 8,
  parameter int TURN_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  output logic               req_ready,
  output logic [31:0]        rsp_rdata,
  input  logic [SETUP_W-1:0] rd_setup,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [TURN_W-1:0]  rd_turn,
  input  logic [SETUP_W-1:0] wr_setup,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [TURN_W-1:0]  wr_turn,
  output logic [ADDR_W-2:0]  mem_addr,
  output logic               mem_cs_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [1:0]         mem_be_n,
  output logic [15:0]        mem_dq_out,
  output logic               mem_dq_oe,
  input  logic [15:0]        mem_dq_in
);

  // request captured at acceptance
  logic              lat_wr;
  xfer_size_e        lat_size;
  logic [ADDR_W-1:0] lat_addr;
  logic [31:0]       lat_wdata;

  logic              cur_wr;
  xfer_size_e        cur_size;
  logic [ADDR_W-1:0] cur_addr;
  logic [31:0]       cur_wdata;

  logic               in_idle, accept, hi_n, cap, fin, act_n;
  phase_e             ph_n;
  logic [SETUP_W-1:0] t_setup;
  logic [DATA_W-1:0]  t_data;
  logic [TURN_W-1:0]  t_turn;
  logic [ADDR_W-2:0]  ln_addr;
  logic [1:0]         ln_be_n;
  logic [15:0]        ln_dq, rd_lo;
  logic [31:0]        ln_rdata;

  always_comb begin
    cur_wr    = in_idle ? req_write : lat_wr;
    cur_size  = in_idle ? xfer_size_e'(req_size) : lat_size;
    cur_addr  = in_idle ? req_addr : lat_addr;
    cur_wdata = in_idle ? req_wdata : lat_wdata;
    act_n     = (ph_n == PH_SETUP) || (ph_n == PH_DATA) || (ph_n == PH_WREL);
  end

  sbb_tsel #(.SETUP_W(SETUP_W), .DATA_W(DATA_W), .TURN_W(TURN_W)) u_tsel (
    .is_wr(cur_wr), .rd_setup(rd_setup), .rd_data(rd_data), .rd_turn(rd_turn),
    .wr_setup(wr_setup), .wr_data(wr_data), .wr_turn(wr_turn),
    .eff_setup(t_setup), .eff_data(t_data), .eff_turn(t_turn)
  );

  sbb_seq #(.SETUP_W(SETUP_W), .DATA_W(DATA_W), .TURN_W(TURN_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .is_wr(cur_wr),
    .split(cur_size == SZ_WORD), .setup_c(t_setup), .data_c(t_data),
    .turn_c(t_turn), .in_idle(in_idle), .accept(accept), .ph_n(ph_n),
    .hi_n(hi_n), .cap(cap), .fin(fin), .ready(req_ready)
  );

  sbb_lane #(.ADDR_W(ADDR_W)) u_lane (
    .size(cur_size), .is_wr(cur_wr), .addr(cur_addr), .wdata(cur_wdata),
    .hi(hi_n), .rd_lo(rd_lo), .rd_now(mem_dq_in), .hw_addr(ln_addr),
    .be_n(ln_be_n), .wdq(ln_dq), .rdata(ln_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_be_n   <= 2'b11;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      lat_wr     <= 1'b0;
      lat_size   <= SZ_BYTE;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      rd_lo      <= '0;
      rsp_rdata  <= '0;
    end else begin
      mem_cs_n  <= !act_n;
      mem_oe_n  <= !((ph_n == PH_DATA) && !cur_wr);
      mem_we_n  <= !((ph_n == PH_DATA) && cur_wr);
      mem_be_n  <= act_n ? ln_be_n : 2'b11;
      mem_dq_oe <= act_n && cur_wr;
      if (act_n) begin
        mem_addr   <= ln_addr;
        mem_dq_out <= ln_dq;
      end
      if (accept) begin
        lat_wr    <= req_write;
        lat_size  <= xfer_size_e'(req_size);
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (cap) begin
        if (fin) rsp_rdata <= ln_rdata;
        else     rd_lo     <= mem_dq_in;
      end
    end
  end

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [15:0]       mem_dq_out,
  input logic [ADDR_W-2:0] mem_addr
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ready));

  p_we_in_cs_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);

  p_we_before_cs_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cs_n) |-> $past(mem_we_n));

  p_we_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));

  p_oe_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  p_no_drive_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  p_ready_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_cs_n);

endmodule

bind sram_bridge sram_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .mem_dq_out(mem_dq_out), .mem_addr(mem_addr)
);

// File: tb/tb_sram_bridge.sv
`timescale 1ns/1ps
module tb_sram_bridge;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready;
  logic [31:0]   rsp_rdata;
  logic [3:0]    rd_setup, wr_setup, rd_turn, wr_turn;
  logic [7:0]    rd_data, wr_data;
  logic [AW-2:0] mem_addr;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [15:0]   mem_dq_out, mem_dq_in;

  logic [15:0] dev  [0:255];
  logic [15:0] gold [0:255];
  int errs = 0, checks = 0, pending = 0, cyc = 0;

  always #4 clk = ~clk;

  sram_bridge #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rd_setup(rd_setup),
    .rd_data(rd_data), .rd_turn(rd_turn), .wr_setup(wr_setup),
    .wr_data(wr_data), .wr_turn(wr_turn), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory device: drives data while output enable is low, writes on write-enable rise
  assign mem_dq_in = mem_oe_n ? 16'h0000 : dev[mem_addr[7:0]];
  always @(posedge mem_we_n) begin
    if (!mem_cs_n) begin
      if (!mem_be_n[0]) dev[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
      if (!mem_be_n[1]) dev[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL R9 watchdog: actual=hung expected=completion");
      finish_run();
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_frame(input string tag, input logic e_cs, input logic e_oe,
                           input logic e_we, input logic [1:0] e_be,
                           input logic [AW-2:0] e_addr, input logic e_dqoe,
                           input logic [15:0] e_dq, input logic e_rdy,
                           input logic e_chkrd, input logic [31:0] e_rd);
    bit bad;
    bad = (mem_cs_n !== e_cs) || (mem_oe_n !== e_oe) || (mem_we_n !== e_we) ||
          (mem_dq_oe !== e_dqoe) || (req_ready !== e_rdy);
    if (!e_cs) bad = bad || (mem_be_n !== e_be) || (mem_addr !== e_addr);
    if (e_dqoe) bad = bad || (mem_dq_out !== e_dq);
    if (e_chkrd) bad = bad || (rsp_rdata !== e_rd);
    checks++;
    if (bad) begin
      errs++;
      $display("FAIL %s cyc %0d: actual cs=%b oe=%b we=%b be=%b addr=%h dqoe=%b dq=%h rdy=%b rd=%h expected cs=%b oe=%b we=%b be=%b addr=%h dqoe=%b dq=%h rdy=%b rd=%h",
               tag, cyc, mem_cs_n, mem_oe_n, mem_we_n, mem_be_n, mem_addr, mem_dq_oe,
               mem_dq_out, req_ready, rsp_rdata, e_cs, e_oe, e_we, e_be, e_addr,
               e_dqoe, e_dq, e_rdy, e_rd);
    end
  endtask

  task automatic idle_frame(input string tag);
    chk_frame(tag, 1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, 16'h0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      step();
      idle_frame("R8");
    end
    pending = (pending > n) ? pending - n : 0;
  endtask

  // one request: presented now, expected waveform built from the requirements
  task automatic run_req(input string tag, input bit wr, input logic [1:0] sz,
                         input logic [AW-1:0] a, input logic [31:0] wd);
    int s, d, t, nh;
    logic [7:0]    hidx;
    logic [AW-2:0] ha;
    logic [1:0]    be;
    logic [15:0]   dq;
    logic [31:0]   erd;
    s = wr ? int'(wr_setup) : int'(rd_setup);
    d = wr ? int'(wr_data)  : int'(rd_data);
    t = wr ? int'(wr_turn)  : int'(rd_turn);
    if (s == 0) s = 1;
    if (d == 0) d = 1;
    req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    for (int i = 0; i < pending; i++) begin
      step();
      idle_frame("R8");
    end
    pending = 0;
    nh = (sz == 2'd2) ? 2 : 1;
    for (int h = 0; h < nh; h++) begin
      ha = a[AW-1:1] + (AW-1)'(h);
      be = (wr && sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b00;
      dq = (sz == 2'd0) ? {wd[7:0], wd[7:0]} : ((h == 1) ? wd[31:16] : wd[15:0]);
      for (int i = 0; i < s; i++) begin
        step(); chk_frame(tag, 1'b0, 1'b1, 1'b1, be, ha, wr, dq, 1'b0, 1'b0, 32'h0);
      end
      for (int i = 0; i < d; i++) begin
        step(); chk_frame(tag, 1'b0, wr, !wr, be, ha, wr, dq, 1'b0, 1'b0, 32'h0);
      end
      if (wr) begin
        step(); chk_frame(tag, 1'b0, 1'b1, 1'b1, be, ha, 1'b1, dq, 1'b0, 1'b0, 32'h0);
      end
      if (h == 0 && nh == 2)
        for (int i = 0; i < t; i++) begin
          step(); idle_frame("R7");
        end
    end
    hidx = a[8:1];
    if (wr) begin
      case (sz)
        2'd0: if (a[0]) gold[hidx][15:8] = wd[7:0]; else gold[hidx][7:0] = wd[7:0];
        2'd1: gold[hidx] = wd[15:0];
        default: begin gold[hidx] = wd[15:0]; gold[8'(hidx + 8'd1)] = wd[31:16]; end
      endcase
    end
    case (sz)
      2'd0: erd = {24'd0, a[0] ? gold[hidx][15:8] : gold[hidx][7:0]};
      2'd1: erd = {16'd0, gold[hidx]};
      default: erd = {gold[8'(hidx + 8'd1)], gold[hidx]};
    endcase
    step();
    chk_frame({tag, " R9"}, 1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, 16'h0, 1'b1, !wr, erd);
    req_valid = 1'b0;
    pending = (t > 0) ? t : 1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dev[i] = 16'h0000;
      gold[i] = 16'h0000;
    end
    rd_setup = 4'd2; rd_data = 8'd3; rd_turn = 4'd1;
    wr_setup = 4'd1; wr_data = 8'd2; wr_turn = 4'd0;
    for (int i = 0; i < 3; i++) begin
      step(); idle_frame("R1");
    end
    rst = 1'b0;
    step(); idle_frame("R1");

    // halfword write/read, then byte lanes
    run_req("R2", 1'b1, 2'd1, 20'h00010, 32'h0000A5C3);
    run_req("R3", 1'b0, 2'd1, 20'h00010, 32'h0);
    run_req("R5", 1'b1, 2'd0, 20'h00011, 32'h0000007E);
    run_req("R6", 1'b0, 2'd1, 20'h00010, 32'h0);
    run_req("R5", 1'b1, 2'd0, 20'h00010, 32'h00000019);
    run_req("R6", 1'b0, 2'd0, 20'h00011, 32'h0);
    run_req("R6", 1'b0, 2'd0, 20'h00010, 32'h0);
    idle(3);
    // word transfers, back to back (valid kept through ready)
    run_req("R7", 1'b1, 2'd2, 20'h00020, 32'h12345678);
    run_req("R7", 1'b0, 2'd2, 20'h00020, 32'h0);
    run_req("R8", 1'b0, 2'd1, 20'h00022, 32'h0);
    run_req("R8", 1'b1, 2'd1, 20'h00040, 32'h0000BEEF);
    run_req("R8", 1'b1, 2'd1, 20'h00042, 32'h0000CAFE);
    idle(4);

    // second timing set: zero counts, turnaround on writes only
    rd_setup = 4'd1; rd_data = 8'd0; rd_turn = 4'd0;
    wr_setup = 4'd3; wr_data = 8'd1; wr_turn = 4'd2;
    idle(2);
    run_req("R10", 1'b0, 2'd1, 20'h00040, 32'h0);
    run_req("R4", 1'b1, 2'd2, 20'h00080, 32'hDEAD0F0F);
    run_req("R4", 1'b0, 2'd2, 20'h00080, 32'h0);
    run_req("R4", 1'b1, 2'd0, 20'h00081, 32'h000000AA);
    run_req("R6", 1'b0, 2'd0, 20'h00081, 32'h0);
    run_req("R6", 1'b0, 2'd1, 20'h00080, 32'h0);
    rd_setup = 4'd0; rd_data = 8'd4; rd_turn = 4'd3;
    idle(2);
    run_req("R10", 1'b0, 2'd2, 20'h00020, 32'h0);
    run_req("R3", 1'b0, 2'd1, 20'h00042, 32'h0);
    idle(5);
    finish_run();
  end

endmodule